// File: doc/BRIEF.md
# Two-Port Memory with Flag-Space Decode

This block is a synchronous 4096 x 8 memory shared by two fully independent ports, called left and right. Each port has an active-low memory select, an active-low flag-space select, an active-low output enable, a read/write line (high reads, low writes), a 12-bit address, 8-bit write data and 8-bit read data with a data-valid flag. The two select lines of a port are decoded every cycle. The result sends the access to the shared array, sends it to a separate space of eight one-bit flags, parks the port in standby, or rejects the access as an illegal select.

The flags are not stored here. A flag access is forwarded to an external flag block through a per-port request interface: request, write strobe, 3-bit flag index and one write bit. The external block returns the current flag value as a single bit in the same cycle. The read result of either space reaches the port's data output one clock later. A flag bit is copied onto every data bit. Standby and illegal-select status come straight from the decoder, with no latency. A one-cycle collision pulse reports that both ports wrote the same word in the same cycle.

Top module: `dual_port_flag_ram`

## Requirements
- R1: With memory select low and flag select high, a port with read/write low writes its data into the addressed word. With read/write high and output enable low, the word appears on that port's read data, with data-valid high, one clock after the read is sampled. The other port can read the same word.
- R2: Both ports can access different words in the same cycle, and each completes with no added delay.
- R3: With memory select high and flag select low, the port raises its flag request with the index equal to address bits 2..0. Address bits 11..3 are ignored, and the memory array is not touched.
- R4: A flag write raises the flag write strobe and passes only write data bit 0 as the flag bit. Bits 7..1 are ignored.
- R5: A flag read with output enable low returns the returned flag bit on all eight read data bits, with data-valid high, one clock later: 8'hFF for 1 and 8'h00 for 0.
- R6: With both selects high, the port's standby status is high, no flag request or memory write takes place, and data-valid is low in the following cycle.
- R7: With both selects low, the port's illegal-select status is high. No memory write and no flag request take place, and data-valid is low in the following cycle.
- R8: A read with output enable high leaves data-valid low and read data 8'h00 in the following cycle.
- R9: When both ports write the same word in the same cycle, the left port's data is stored, and the collision output is high for exactly the following cycle.
- R10: When one port reads a word that the other port writes in the same cycle, the read returns the value held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| l_mem_sel_n | input | 1 | Left memory select, active low |
| l_flag_sel_n | input | 1 | Left flag-space select, active low |
| l_oe_n | input | 1 | Left output enable, active low |
| l_rd_wr_n | input | 1 | Left read (1) / write (0) |
| l_addr | input | 12 | Left address |
| l_wdata | input | 8 | Left write data |
| l_rdata | output | 8 | Left read data, 0 when not valid |
| l_rvalid | output | 1 | Left read data valid |
| l_standby | output | 1 | Left port in standby |
| l_bad_sel | output | 1 | Left illegal select combination |
| l_flag_req | output | 1 | Left request to the flag block |
| l_flag_wr | output | 1 | Left flag write strobe |
| l_flag_idx | output | 3 | Left flag index |
| l_flag_bit | output | 1 | Left flag write value |
| l_flag_rbit | input | 1 | Flag value returned to the left port |
| r_mem_sel_n | input | 1 | Right memory select, active low |
| r_flag_sel_n | input | 1 | Right flag-space select, active low |
| r_oe_n | input | 1 | Right output enable, active low |
| r_rd_wr_n | input | 1 | Right read (1) / write (0) |
| r_addr | input | 12 | Right address |
| r_wdata | input | 8 | Right write data |
| r_rdata | output | 8 | Right read data, 0 when not valid |
| r_rvalid | output | 1 | Right read data valid |
| r_standby | output | 1 | Right port in standby |
| r_bad_sel | output | 1 | Right illegal select combination |
| r_flag_req | output | 1 | Right request to the flag block |
| r_flag_wr | output | 1 | Right flag write strobe |
| r_flag_idx | output | 3 | Right flag index |
| r_flag_bit | output | 1 | Right flag write value |
| r_flag_rbit | input | 1 | Flag value returned to the right port |
| collision | output | 1 | One-cycle pulse after a same-word write from both ports |

## Verification
The two port functions that can meet in one cycle are accesses by both sides to the same array word. The bench provokes this in two ways. In the first, both sides write one word in the same cycle. The bench then judges the collision pulse in the next cycle only, and afterwards reads the word back expecting the left value. In the second, one side reads a word while the other overwrites it. The bench expects the pre-write value on the reader and the new value on a later read.

// File: rtl/dpfr_pkg.sv
package dpfr_pkg;
  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_MEM  = 2'd1,
    ACC_FLAG = 2'd2,
    ACC_BAD  = 2'd3
  } acc_e;
endpackage

// File: rtl/dpfr_port_decode.sv
module dpfr_port_decode
  import dpfr_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8,
  parameter int IDX_W  = 3
) (
  input  logic              mem_sel_n,
  input  logic              flag_sel_n,
  input  logic              oe_n,
  input  logic              rd_wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic              show_mem,
  output logic              show_flag,
  output logic              flag_req,
  output logic              flag_wr,
  output logic [IDX_W-1:0]  flag_idx,
  output logic              flag_bit,
  output logic              standby,
  output logic              bad_sel
);
  acc_e kind;

  always_comb begin
    unique case ({mem_sel_n, flag_sel_n})
      2'b01:   kind = ACC_MEM;
      2'b10:   kind = ACC_FLAG;
      2'b11:   kind = ACC_NONE;
      default: kind = ACC_BAD;
    endcase
  end

  always_comb begin
    mem_rd    = (kind == ACC_MEM) && rd_wr_n;
    mem_wr    = (kind == ACC_MEM) && !rd_wr_n;
    show_mem  = mem_rd && !oe_n;
    flag_req  = (kind == ACC_FLAG);
    flag_wr   = flag_req && !rd_wr_n;
    show_flag = flag_req && rd_wr_n && !oe_n;
    flag_idx  = addr[IDX_W-1:0];
    flag_bit  = wdata[0];
    standby   = (kind == ACC_NONE);
    bad_sel   = (kind == ACC_BAD);
  end
endmodule

// File: rtl/dpfr_mem_array.sv
module dpfr_mem_array #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_rd,
  input  logic              a_wr,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  input  logic              b_rd,
  input  logic              b_wr,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] a_q,
  output logic [DATA_W-1:0] b_q,
  output logic              collide
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store [DEPTH];
  logic              same_wr;
  logic              b_wr_ok;
  logic              collide_q;

  always_comb begin
    same_wr = a_wr && b_wr && (a_addr == b_addr);
    b_wr_ok = b_wr && !same_wr;
  end

  // array and read registers carry no reset
  always_ff @(posedge clk) begin
    if (b_wr_ok) store[b_addr] <= b_wdata;
    if (a_wr)    store[a_addr] <= a_wdata;
    if (a_rd)    a_q <= store[a_addr];
    if (b_rd)    b_q <= store[b_addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) collide_q <= 1'b0;
    else        collide_q <= same_wr;
  end

  assign collide = collide_q;
endmodule

// File: rtl/dpfr_port_out.sv
module dpfr_port_out #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              show_mem,
  input  logic              show_flag,
  input  logic              flag_rbit,
  input  logic [DATA_W-1:0] mem_q,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  logic vld_q, vld_d;
  logic src_flag_q, src_flag_d;
  logic flag_q, flag_d;
  logic flag_en;

  always_comb begin
    vld_d      = show_mem || show_flag;
    src_flag_d = show_flag;
    flag_en    = show_flag;
    flag_d     = flag_rbit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q      <= 1'b0;
      src_flag_q <= 1'b0;
      flag_q     <= 1'b0;
    end else begin
      vld_q      <= vld_d;
      src_flag_q <= src_flag_d;
      if (flag_en) flag_q <= flag_d;
    end
  end

  always_comb begin
    if (!vld_q)          rdata = '0;
    else if (src_flag_q) rdata = {DATA_W{flag_q}};
    else                 rdata = mem_q;
    rvalid = vld_q;
  end
endmodule

// File: rtl/dual_port_flag_ram.sv
module dual_port_flag_ram #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_mem_sel_n,
  input  logic              l_flag_sel_n,
  input  logic              l_oe_n,
  input  logic              l_rd_wr_n,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  output logic              l_rvalid,
  output logic              l_standby,
  output logic              l_bad_sel,
  output logic              l_flag_req,
  output logic              l_flag_wr,
  output logic [IDX_W-1:0]  l_flag_idx,
  output logic              l_flag_bit,
  input  logic              l_flag_rbit,
  input  logic              r_mem_sel_n,
  input  logic              r_flag_sel_n,
  input  logic              r_oe_n,
  input  logic              r_rd_wr_n,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata,
  output logic              r_rvalid,
  output logic              r_standby,
  output logic              r_bad_sel,
  output logic              r_flag_req,
  output logic              r_flag_wr,
  output logic [IDX_W-1:0]  r_flag_idx,
  output logic              r_flag_bit,
  input  logic              r_flag_rbit,
  output logic              collision
);
  logic [1:0] rst_pipe;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q_n = rst_pipe[1];

  logic l_mem_rd, l_mem_wr, l_show_mem, l_show_flag;
  logic r_mem_rd, r_mem_wr, r_show_mem, r_show_flag;
  logic [DATA_W-1:0] l_mem_q, r_mem_q;

  dpfr_port_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_dec_l (
    .mem_sel_n(l_mem_sel_n), .flag_sel_n(l_flag_sel_n), .oe_n(l_oe_n),
    .rd_wr_n(l_rd_wr_n), .addr(l_addr), .wdata(l_wdata),
    .mem_rd(l_mem_rd), .mem_wr(l_mem_wr), .show_mem(l_show_mem),
    .show_flag(l_show_flag), .flag_req(l_flag_req), .flag_wr(l_flag_wr),
    .flag_idx(l_flag_idx), .flag_bit(l_flag_bit),
    .standby(l_standby), .bad_sel(l_bad_sel)
  );

  dpfr_port_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_dec_r (
    .mem_sel_n(r_mem_sel_n), .flag_sel_n(r_flag_sel_n), .oe_n(r_oe_n),
    .rd_wr_n(r_rd_wr_n), .addr(r_addr), .wdata(r_wdata),
    .mem_rd(r_mem_rd), .mem_wr(r_mem_wr), .show_mem(r_show_mem),
    .show_flag(r_show_flag), .flag_req(r_flag_req), .flag_wr(r_flag_wr),
    .flag_idx(r_flag_idx), .flag_bit(r_flag_bit),
    .standby(r_standby), .bad_sel(r_bad_sel)
  );

  dpfr_mem_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk(clk), .rst_n(rst_q_n),
    .a_rd(l_mem_rd), .a_wr(l_mem_wr), .a_addr(l_addr), .a_wdata(l_wdata),
    .b_rd(r_mem_rd), .b_wr(r_mem_wr), .b_addr(r_addr), .b_wdata(r_wdata),
    .a_q(l_mem_q), .b_q(r_mem_q), .collide(collision)
  );

  dpfr_port_out #(.DATA_W(DATA_W)) u_out_l (
    .clk(clk), .rst_n(rst_q_n), .show_mem(l_show_mem), .show_flag(l_show_flag),
    .flag_rbit(l_flag_rbit), .mem_q(l_mem_q), .rdata(l_rdata), .rvalid(l_rvalid)
  );

  dpfr_port_out #(.DATA_W(DATA_W)) u_out_r (
    .clk(clk), .rst_n(rst_q_n), .show_mem(r_show_mem), .show_flag(r_show_flag),
    .flag_rbit(r_flag_rbit), .mem_q(r_mem_q), .rdata(r_rdata), .rvalid(r_rvalid)
  );

  // R7: an illegal select never reaches the flag block
  assert_bad_no_flag_R7: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!l_mem_sel_n && !l_flag_sel_n) |-> !l_flag_req);

  // R6: standby leaves the following cycle without valid data
  assert_standby_quiet_R6: assert property (@(posedge clk) disable iff (!rst_q_n)
    (l_mem_sel_n && l_flag_sel_n) |=> !l_rvalid);

  // R8: output enable high suppresses the result
  assert_oe_gate_R8: assert property (@(posedge clk) disable iff (!rst_q_n)
    (r_oe_n && r_rd_wr_n) |=> (!r_rvalid && r_rdata == '0));

  // R5: a flag read result is all ones or all zeros
  assert_flag_spread_R5: assert property (@(posedge clk) disable iff (!rst_q_n)
    (l_mem_sel_n && !l_flag_sel_n && l_rd_wr_n && !l_oe_n)
      |=> (l_rvalid && (l_rdata == '0 || l_rdata == '1)));

  // R9: the collision pulse follows a same-word double write only
  assert_collision_cause_R9: assert property (@(posedge clk) disable iff (!rst_q_n)
    collision |-> $past(!l_mem_sel_n && l_flag_sel_n && !l_rd_wr_n &&
                        !r_mem_sel_n && r_flag_sel_n && !r_rd_wr_n &&
                        l_addr == r_addr));
endmodule

// File: tb/dual_port_flag_ram_bench.sv
module dual_port_flag_ram_bench;
  logic clk = 1'b0;
  logic rst_n;
  logic l_ms, l_fs, l_oe, l_rw, l_rb;
  logic r_ms, r_fs, r_oe, r_rw, r_rb;
  logic [11:0] l_a, r_a;
  logic [7:0]  l_d, r_d;
  logic [7:0]  l_q, r_q;
  logic l_v, r_v, l_sb, r_sb, l_bad, r_bad;
  logic l_req, r_req, l_fw, r_fw, l_fb, r_fb, coll;
  logic [2:0] l_idx, r_idx;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dual_port_flag_ram u_dual_port_flag_ram (
    .clk(clk), .rst_n(rst_n),
    .l_mem_sel_n(l_ms), .l_flag_sel_n(l_fs), .l_oe_n(l_oe), .l_rd_wr_n(l_rw),
    .l_addr(l_a), .l_wdata(l_d), .l_rdata(l_q), .l_rvalid(l_v),
    .l_standby(l_sb), .l_bad_sel(l_bad), .l_flag_req(l_req), .l_flag_wr(l_fw),
    .l_flag_idx(l_idx), .l_flag_bit(l_fb), .l_flag_rbit(l_rb),
    .r_mem_sel_n(r_ms), .r_flag_sel_n(r_fs), .r_oe_n(r_oe), .r_rd_wr_n(r_rw),
    .r_addr(r_a), .r_wdata(r_d), .r_rdata(r_q), .r_rvalid(r_v),
    .r_standby(r_sb), .r_bad_sel(r_bad), .r_flag_req(r_req), .r_flag_wr(r_fw),
    .r_flag_idx(r_idx), .r_flag_bit(r_fb), .r_flag_rbit(r_rb),
    .collision(coll)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drv_l(logic ms, logic fs, logic rw, logic oe, logic [11:0] a, logic [7:0] d);
    l_ms = ms; l_fs = fs; l_rw = rw; l_oe = oe; l_a = a; l_d = d;
  endtask

  task automatic drv_r(logic ms, logic fs, logic rw, logic oe, logic [11:0] a, logic [7:0] d);
    r_ms = ms; r_fs = fs; r_rw = rw; r_oe = oe; r_a = a; r_d = d;
  endtask

  task automatic idle();
    drv_l(1, 1, 1, 1, 12'h000, 8'h00);
    drv_r(1, 1, 1, 1, 12'h000, 8'h00);
  endtask

  task automatic t_mem_rw();
    drv_l(0, 1, 0, 1, 12'h123, 8'h5A); step();
    drv_l(0, 1, 1, 0, 12'h123, 8'h00);
    drv_r(0, 1, 1, 0, 12'h123, 8'h00); step();
    check("R1 left read data", l_q, 8'h5A);
    check("R1 left valid", l_v, 1);
    check("R1 right read same word", r_q, 8'h5A);
    idle(); step();
  endtask

  task automatic t_parallel();
    drv_l(0, 1, 0, 1, 12'h010, 8'h11);
    drv_r(0, 1, 0, 1, 12'h020, 8'h22); step();
    check("R2 no collision on distinct words", coll, 0);
    drv_l(0, 1, 1, 0, 12'h020, 8'h00);
    drv_r(0, 1, 1, 0, 12'h010, 8'h00); step();
    check("R2 left sees right write", l_q, 8'h22);
    check("R2 right sees left write", r_q, 8'h11);
    idle(); step();
  endtask

  task automatic t_flag();
    drv_l(0, 1, 0, 1, 12'hFFD, 8'h77); step();
    drv_l(1, 0, 0, 1, 12'hFFD, 8'hFE);
    #1;
    check("R3 flag request", l_req, 1);
    check("R3 flag index from low bits", l_idx, 3'd5);
    check("R4 flag write strobe", l_fw, 1);
    check("R4 only bit 0 passed", l_fb, 0);
    step();
    drv_l(0, 1, 1, 0, 12'hFFD, 8'h00); step();
    check("R3 array untouched by flag write", l_q, 8'h77);
    drv_l(1, 0, 1, 0, 12'h00A, 8'h00); l_rb = 1'b1;
    #1;
    check("R3 read index", l_idx, 3'd2);
    check("R4 no strobe on read", l_fw, 0);
    step();
    check("R5 flag one spread", l_q, 8'hFF);
    check("R5 flag valid", l_v, 1);
    drv_r(1, 0, 1, 0, 12'h7F3, 8'h00); r_rb = 1'b0; step();
    check("R5 flag zero spread", r_q, 8'h00);
    check("R5 flag zero valid", r_v, 1);
    idle(); l_rb = 1'b0; step();
  endtask

  task automatic t_standby();
    drv_l(1, 1, 0, 0, 12'h123, 8'h00);
    #1;
    check("R6 standby status", l_sb, 1);
    check("R6 no flag request", l_req, 0);
    step();
    check("R6 no valid data", l_v, 0);
    drv_l(0, 1, 1, 0, 12'h123, 8'h00); step();
    check("R6 no write in standby", l_q, 8'h5A);
    idle(); step();
  endtask

  task automatic t_bad();
    drv_l(0, 0, 0, 0, 12'h123, 8'hEE);
    #1;
    check("R7 illegal select flagged", l_bad, 1);
    check("R7 no flag request", l_req, 0);
    check("R7 not standby", l_sb, 0);
    step();
    check("R7 no valid data", l_v, 0);
    drv_l(0, 1, 1, 0, 12'h123, 8'h00); step();
    check("R7 no memory write", l_q, 8'h5A);
    idle(); step();
  endtask

  task automatic t_oe();
    drv_r(0, 1, 1, 1, 12'h123, 8'h00); step();
    check("R8 valid low with oe high", r_v, 0);
    check("R8 data zero with oe high", r_q, 8'h00);
    idle(); step();
  endtask

  task automatic t_collide();
    drv_l(0, 1, 0, 1, 12'h200, 8'hAA);
    drv_r(0, 1, 0, 1, 12'h200, 8'hBB); step();
    check("R9 collision pulse", coll, 1);
    idle(); step();
    check("R9 collision one cycle", coll, 0);
    drv_r(0, 1, 1, 0, 12'h200, 8'h00); step();
    check("R9 left data kept", r_q, 8'hAA);
    idle(); step();
  endtask

  task automatic t_rbw();
    drv_l(0, 1, 0, 1, 12'h300, 8'h31); step();
    drv_l(0, 1, 1, 0, 12'h300, 8'h00);
    drv_r(0, 1, 0, 1, 12'h300, 8'h99); step();
    check("R10 old data on read", l_q, 8'h31);
    check("R10 no collision for read", coll, 0);
    drv_l(0, 1, 1, 0, 12'h300, 8'h00);
    drv_r(1, 1, 1, 1, 12'h000, 8'h00); step();
    check("R10 new data afterwards", l_q, 8'h99);
    idle(); step();
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 1'b0; l_rb = 1'b0; r_rb = 1'b0;
    idle();
    repeat (3) @(negedge clk);
    check("R6 reset left valid low", l_v, 0);
    check("R9 reset collision low", coll, 0);
    check("R6 reset standby status", l_sb, 1);
    rst_n = 1'b1;
    repeat (3) step();
    t_mem_rw();
    t_parallel();
    t_flag();
    t_standby();
    t_bad();
    t_oe();
    t_collide();
    t_rbw();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule